// File: doc/BRIEF.md
# Valley Lockout Selector

This block picks the resonant valley in which the next switching cycle of a quasi-resonant converter should begin. When the output-current reference is so low that even the deepest valley would switch too fast, it raises a frequency-foldback flag instead. The reference arrives as a percentage code from 0 to 100. The selection uses pairs of thresholds with hysteresis, so a reference near a threshold does not toggle between two valleys.

A line-range detector sits in front of the map. It takes two line comparators: one reports that the line is above the high-line threshold, the other that it is below the low-line threshold. A new range is taken only after the opposing comparator has been held for a blanking window. At high line the whole map moves one valley deeper. The valley counter, dead-time generation and analog sensing lie outside the block. The selection is committed only on a pulse that marks the start of a switching cycle.

Top module: `valley_lockout_sel`

## Requirements
- R1: During and after reset, before the first cycle-start pulse, `valley` is 1 and `foldback` is 0, and the line range is low.
- R2: As the reference falls, the low-line valley moves one deeper when the reference is strictly below 80, 65, 50 and 35 (valleys 1 to 5).
- R3: As the reference rises, the valley moves one shallower when the reference is strictly above 90, 75, 60 and 45.
- R4: A reference that lies between the falling and rising thresholds of the current valley leaves the valley unchanged.
- R5: Foldback is entered when the reference is strictly below 25 and left when it is strictly above 35. On leaving, the selection goes to the deepest valley of the map.
- R6: A single cycle-start pulse can move the selection across several thresholds at once, to the level the hysteresis rules give for the present reference.
- R7: `valley` and `foldback` change only at a clock edge where `cyc_start` is 1. The new value appears at that edge.
- R8: The line range becomes high after `line_above_hi` has been 1 for BLANK_CYC consecutive clock edges (default 64). A shorter run has no effect.
- R9: The line range returns to low after `line_below_lo` has been 1 for BLANK_CYC consecutive clock edges. A shorter run has no effect.
- R10: At high line the reported valley is the low-line valley plus one (range 2 to 6). The line range is applied at the next cycle-start pulse.
- R11: While `foldback` is 1, `valley` reports the deepest valley of the present map: 5 at low line, 6 at high line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_start | input | 1 | Pulse marking a switching-cycle boundary |
| ref_pct | input | REF_W (7) | Output-current reference in percent, 0 to 100 |
| line_above_hi | input | 1 | Line comparator: above the high-line threshold |
| line_below_lo | input | 1 | Line comparator: below the low-line threshold |
| valley | output | VW (3) | Selected valley, 1 to 6 |
| foldback | output | 1 | Frequency-foldback mode requested |

## Verification
The bench places the reference exactly on each threshold and one code beyond it, in both directions. A comparison written with the wrong strictness, or a swapped hysteresis pair, then shows up as a valley change that comes one code early or one code late. References parked inside the hysteresis bands catch a design that tracks the reference with no memory. A large single-cycle drop and a large single-cycle rise catch a design that moves only one step per cycle.

Comparator runs of BLANK_CYC-1 and BLANK_CYC edges separate a correct blanking counter from one that is off by one, or one that fails to clear on a gap. Changing the reference with no cycle-start pulse catches a design that updates in the middle of a cycle.

// File: rtl/valley_lockout_sel.sv
module valley_lockout_sel #(
  parameter int REF_W     = 7,
  parameter int NLVL      = 5,
  parameter int BLANK_CYC = 64,
  parameter int DN_TH [NLVL] = '{80, 65, 50, 35, 25},
  parameter int UP_TH [NLVL] = '{90, 75, 60, 45, 35},
  localparam int VW = $clog2(NLVL + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_start,
  input  logic [REF_W-1:0] ref_pct,
  input  logic             line_above_hi,
  input  logic             line_below_lo,
  output logic [VW-1:0]    valley,
  output logic             foldback
);
  localparam int LW = $clog2(NLVL + 1);
  localparam int CW = $clog2(BLANK_CYC + 1);

  logic [NLVL-1:0] dn_hit, up_hit;
  logic [LW-1:0]   lvl, dn_lvl, up_lvl, nxt_lvl, deep_lvl;
  logic [CW-1:0]   blank_cnt;
  logic            high_line;
  logic            line_req;

  for (genvar k = 0; k < NLVL; k++) begin : g_cmp
    assign dn_hit[k] = int'(ref_pct) <  DN_TH[k];
    assign up_hit[k] = int'(ref_pct) <= UP_TH[k];
  end

  always_comb begin
    dn_lvl = '0;
    up_lvl = '0;
    for (int k = 0; k < NLVL; k++) begin
      dn_lvl = dn_lvl + LW'(dn_hit[k]);
      up_lvl = up_lvl + LW'(up_hit[k]);
    end
  end

  assign nxt_lvl  = (lvl < dn_lvl) ? dn_lvl : (lvl > up_lvl) ? up_lvl : lvl;
  assign deep_lvl = (nxt_lvl >= LW'(NLVL)) ? LW'(NLVL - 1) : nxt_lvl;
  assign line_req = high_line ? line_below_lo : line_above_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      high_line <= 1'b0;
      blank_cnt <= '0;
    end else if (line_req) begin
      if (blank_cnt == CW'(BLANK_CYC - 1)) begin
        high_line <= ~high_line;
        blank_cnt <= '0;
      end else begin
        blank_cnt <= blank_cnt + 1'b1;
      end
    end else begin
      blank_cnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl      <= '0;
      valley   <= VW'(1);
      foldback <= 1'b0;
    end else if (cyc_start) begin
      lvl      <= nxt_lvl;
      valley   <= VW'(deep_lvl) + VW'(1) + VW'(high_line);
      foldback <= (nxt_lvl == LW'(NLVL));
    end
  end
endmodule

module valley_lockout_chk #(
  parameter int REF_W = 7,
  parameter int VW    = 3,
  parameter int FF_ON  = 25,
  parameter int FF_OFF = 35
) (
  input logic             clk,
  input logic             rst,
  input logic             cyc_start,
  input logic [REF_W-1:0] ref_pct,
  input logic [VW-1:0]    valley,
  input logic             foldback
);
  a_r7_hold_between_cycles: assert property (@(posedge clk) disable iff (rst)
    !$past(cyc_start) |-> ($stable(valley) && $stable(foldback)));

  a_r10_valley_range: assert property (@(posedge clk) disable iff (rst)
    (valley >= VW'(1)) && (valley <= VW'(6)));

  a_r5_ff_enter: assert property (@(posedge clk) disable iff (rst)
    $rose(foldback) |-> (int'($past(ref_pct)) < FF_ON));

  a_r5_ff_exit: assert property (@(posedge clk) disable iff (rst)
    $fell(foldback) |-> (int'($past(ref_pct)) > FF_OFF));

  a_r11_ff_deep: assert property (@(posedge clk) disable iff (rst)
    foldback |-> (valley >= VW'(5)));
endmodule

bind valley_lockout_sel valley_lockout_chk #(.REF_W(REF_W), .VW(VW)) u_chk (
  .clk(clk), .rst(rst), .cyc_start(cyc_start), .ref_pct(ref_pct),
  .valley(valley), .foldback(foldback));

// File: tb/tb_valley_lockout_sel.sv
module tb_valley_lockout_sel;
  localparam int BLANK = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cyc_start = 1'b0;
  logic [6:0] ref_pct = 7'd100;
  logic       line_above_hi = 1'b0;
  logic       line_below_lo = 1'b0;
  logic [2:0] valley;
  logic       foldback;

  int checks = 0;
  int errors = 0;

  typedef struct { int v; bit ff; string tag; } exp_t;
  exp_t q[$];

  int  m_lvl = 0;
  bit  m_high = 0;
  bit  pend = 0;
  bit  done = 0;

  always #2.5 clk = ~clk;

  valley_lockout_sel dut (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .ref_pct(ref_pct),
    .line_above_hi(line_above_hi), .line_below_lo(line_below_lo),
    .valley(valley), .foldback(foldback));

  function automatic int dn_th(int k);
    case (k) 0: return 80; 1: return 65; 2: return 50; 3: return 35; default: return 25; endcase
  endfunction
  function automatic int up_th(int k);
    case (k) 0: return 90; 1: return 75; 2: return 60; 3: return 45; default: return 35; endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_cycle(int r, string tag);
    exp_t e;
    ref_pct = 7'(r);
    while (m_lvl < 5 && r < dn_th(m_lvl)) m_lvl++;
    while (m_lvl > 0 && r > up_th(m_lvl - 1)) m_lvl--;
    e.ff  = (m_lvl == 5);
    e.v   = (m_lvl == 5 ? 4 : m_lvl) + 1 + int'(m_high);
    e.tag = tag;
    q.push_back(e);
    cyc_start = 1'b1;
    step();
    cyc_start = 1'b0;
    step();
  endtask

  always @(negedge clk) begin
    if (pend) begin
      exp_t e;
      if (q.size() == 0) begin
        chk("scoreboard_underflow", 1, 0);
      end else begin
        e = q.pop_front();
        chk({e.tag, " valley"}, int'(valley), e.v);
        chk({e.tag, " foldback"}, int'(foldback), int'(e.ff));
      end
    end
    pend = cyc_start;
  end

  task automatic hold_line(bit hi, int n);
    if (hi) line_above_hi = 1'b1; else line_below_lo = 1'b1;
    repeat (n) step();
    line_above_hi = 1'b0;
    line_below_lo = 1'b0;
    step();
  endtask

  initial begin
    fork
      begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog actual=timeout expected=finish");
        end
      end
      begin : main
        repeat (3) step();
        @(negedge clk);
        chk("R1 reset valley", int'(valley), 1);
        chk("R1 reset foldback", int'(foldback), 0);
        rst = 1'b0;
        step();
        @(negedge clk);
        chk("R1 after reset valley", int'(valley), 1);
        step();

        do_cycle(100, "R2 full ref");
        do_cycle(80,  "R4 at 80 stays");
        do_cycle(79,  "R2 below 80");
        do_cycle(65,  "R4 at 65 stays");
        do_cycle(64,  "R2 below 65");
        do_cycle(49,  "R2 below 50");
        do_cycle(34,  "R2 below 35");
        do_cycle(25,  "R5 at 25 no ff");
        do_cycle(24,  "R5 enter ff");
        do_cycle(35,  "R5 at 35 stays ff");
        do_cycle(36,  "R5 exit ff");
        do_cycle(45,  "R4 at 45 stays");
        do_cycle(46,  "R3 above 45");
        do_cycle(61,  "R3 above 60");
        do_cycle(75,  "R4 at 75 stays");
        do_cycle(76,  "R3 above 75");
        do_cycle(85,  "R4 band 80 to 90");
        do_cycle(91,  "R3 above 90");
        do_cycle(10,  "R6 jump to ff");
        do_cycle(95,  "R6 jump to first");

        ref_pct = 7'd30;
        repeat (4) step();
        @(negedge clk);
        chk("R7 no pulse valley", int'(valley), 1);
        chk("R7 no pulse foldback", int'(foldback), 0);
        step();

        hold_line(1'b1, BLANK - 1);
        do_cycle(100, "R8 short run ignored");
        hold_line(1'b1, BLANK);
        m_high = 1;
        do_cycle(100, "R10 high line first");
        do_cycle(70,  "R10 high line shift");
        do_cycle(20,  "R11 ff at high line");
        hold_line(1'b0, BLANK - 1);
        do_cycle(20,  "R9 short run ignored");
        hold_line(1'b0, BLANK);
        m_high = 0;
        do_cycle(20,  "R9 back to low line");
        do_cycle(100, "R9 low line full ref");

        repeat (3) step();
        chk("scoreboard_empty", q.size(), 0);
        done = 1;
        disable watchdog;
      end
    join
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule